// File: doc/BRIEF.md
# Floating-Point Invalid-Operand Detector

This block sits next to a floating-point execution unit and decides, for each issued operation, whether the operation is mathematically undefined for its operands. Its inputs are an operation code, a class code and a sign for the source operand and for the register operand, and a few side flags from the datapath. The side flags report a source magnitude above one, integer-conversion overflow, a decimal exponent out of range, and a k-factor out of range. Arithmetic itself is done elsewhere. The block only flags an operand error and chooses the write policy.

The write policy depends on a trap-enable bit and on the destination kind. If the trap is off, a flagged result is replaced by the default quiet NaN and written. If the trap is on and the destination is a floating-point register, the write is blocked. If the trap is on and the destination is memory or an integer register, the default NaN is written and a mid-instruction exception is requested. A sticky status bit records every flagged operation until software-side logic pulses the clear input.

The decision is held in a small state machine, so every output appears in the cycle after the valid strobe. It has five states:
- `ST_IDLE`: nothing issued.
- `ST_PASS`: clean operation, normal write.
- `ST_NAN_QUIET`: error with the trap off.
- `ST_SUPPRESS`: error with the trap on and a floating-point register destination.
- `ST_NAN_TRAP`: error with the trap on and an external destination.

On every clock edge the next state is chosen as follows:
- No valid strobe leads to `ST_IDLE`.
- A valid operation with no error leads to `ST_PASS`.
- A valid error with the trap off leads to `ST_NAN_QUIET`.
- A valid error with the trap on leads to `ST_SUPPRESS` or to `ST_NAN_TRAP`, depending on the destination.

Any state can reach any other in one step.

Top module: `fp_operr_detector`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signaling NaN. Add (opcode 0) flags an error when both operands are infinite with differing signs. Subtract (opcode 1) flags an error when both operands are infinite with equal signs.
- R2: Multiply (2) and single-precision multiply (4) flag an error when one operand is zero and the other is infinite. Divide (3) and single-precision divide (5) flag an error for zero over zero or infinity over infinity.
- R3: Arc-cosine (6), arc-sine (7) and inverse hyperbolic tangent (8) flag an error for an infinite source, or for a finite nonzero source whose magnitude-above-one flag is set.
- R4: Sine (9), cosine (10), tangent (11), sine-cosine (12), get-exponent (21) and get-mantissa (22) flag an error exactly when the source is infinite.
- R5: Natural log (13), base-2 log (14), base-10 log (15) and square root (16) flag an error for a negative normal, denormal or infinite source. A negative zero raises no error.
- R6: Log-of-one-plus-x (17) flags an error for negative infinity, or for a negative finite source with the magnitude-above-one flag set. A source of exactly minus one raises no error.
- R7: Modulo (18) and remainder (19) flag an error when the register operand is infinite or the source is zero. Scale (20) flags an error for an infinite source. For every two-operand operation (opcodes 0 to 5 and 18 to 20), a NaN in either operand cancels the error.
- R8: Conversion to integer (23) flags an error for an infinite source, a quiet NaN source, or the overflow flag with a zero, normal or denormal source. A signaling NaN source raises no error.
- R9: Conversion to packed decimal (24) flags an error when the exponent-range flag or the k-factor flag is set. Opcodes 25 to 31 never flag an error.
- R10: Outputs reflect the operation presented with the valid strobe at the following clock edge. A cycle without the strobe shows all four result outputs low. A clean operation shows only the write enable high. Reset clears every output.
- R11: With the trap disabled, a flagged operation shows the error flag, the write enable and the NaN select high, and no exception request.
- R12: With the trap enabled and destination code 0 (floating-point register), a flagged operation shows the error flag high and the write enable, the NaN select and the exception request low.
- R13: With the trap enabled and destination code 1 (memory) or 2 (integer register), a flagged operation shows the error flag, the write enable, the NaN select and the exception request all high.
- R14: The sticky bit goes high in the same cycle as any error flag and stays high until a clear pulse. A clear pulse lowers it at the next edge unless that edge also captures a flagged operation, in which case it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| opcode_i | input | 5 | Operation code |
| src_cls_i | input | 3 | Source operand class |
| src_neg_i | input | 1 | Source sign |
| reg_cls_i | input | 3 | Register operand class |
| reg_neg_i | input | 1 | Register operand sign |
| src_gt_one_i | input | 1 | Finite source magnitude exceeds one |
| int_ovf_i | input | 1 | Integer conversion would overflow |
| dec_exp_big_i | input | 1 | Decimal result exponent above 999 |
| kfac_big_i | input | 1 | k-factor above +17 |
| dest_i | input | 2 | Destination kind: 0 FP register, 1 memory, 2 integer register |
| trap_en_i | input | 1 | Operand-error trap enable |
| clr_sticky_i | input | 1 | Clears the sticky status bit |
| op_err_o | output | 1 | Operand error flag |
| wr_en_o | output | 1 | Destination write enable |
| force_nan_o | output | 1 | Select the default quiet NaN as result |
| exc_req_o | output | 1 | Mid-instruction exception request |
| sticky_o | output | 1 | Sticky operand-error status |

## Verification
The assertions take the destination code to be 0, 1 or 2, and the class codes to be 0 to 5. They also assume the datapath side flags are presented together with the valid strobe. The random stimulus draws class codes modulo six and destinations modulo three, so it stays inside these encodings. It toggles the side flags freely, which exercises cases where a flag must be ignored, such as an overflow flag with a NaN source. Directed cases cover the edges: exact minus one, negative zero, signaling NaN, and a clear pulse that coincides with an error.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int OPC_W = 5;
    localparam int CLS_W = 3;
    localparam int DST_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO   = 3'd0,
        CLS_NORM   = 3'd1,
        CLS_DENORM = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } fp_class_e;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD     = 5'd0,
        OP_SUB     = 5'd1,
        OP_MUL     = 5'd2,
        OP_DIV     = 5'd3,
        OP_SMUL    = 5'd4,
        OP_SDIV    = 5'd5,
        OP_ACOS    = 5'd6,
        OP_ASIN    = 5'd7,
        OP_ATANH   = 5'd8,
        OP_SIN     = 5'd9,
        OP_COS     = 5'd10,
        OP_TAN     = 5'd11,
        OP_SINCOS  = 5'd12,
        OP_LN      = 5'd13,
        OP_LOG2    = 5'd14,
        OP_LOG10   = 5'd15,
        OP_SQRT    = 5'd16,
        OP_LNP1    = 5'd17,
        OP_MOD     = 5'd18,
        OP_REM     = 5'd19,
        OP_SCALE   = 5'd20,
        OP_GEXP    = 5'd21,
        OP_GMAN    = 5'd22,
        OP_TOINT   = 5'd23,
        OP_TOPACK  = 5'd24,
        OP_MOVE    = 5'd25
    } fp_op_e;

    typedef enum logic [DST_W-1:0] {
        DST_FREG = 2'd0,
        DST_MEM  = 2'd1,
        DST_IREG = 2'd2
    } fp_dest_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PASS      = 3'd1,
        ST_NAN_QUIET = 3'd2,
        ST_SUPPRESS  = 3'd3,
        ST_NAN_TRAP  = 3'd4
    } policy_state_e;

endpackage

// File: rtl/fpe_domain_check.sv
module fpe_domain_check
    import fpe_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [CLS_W-1:0] src_cls_i,
    input  logic             src_neg_i,
    input  logic [CLS_W-1:0] reg_cls_i,
    input  logic             reg_neg_i,
    input  logic             src_gt_one_i,
    input  logic             int_ovf_i,
    input  logic             dec_exp_big_i,
    input  logic             kfac_big_i,
    output logic             err_o
);

    logic s_zero, s_inf, s_nan, s_qnan, s_fin_nz;
    logic r_zero, r_inf, r_nan;
    logic s_negval, s_big, any_nan, dyadic, raw_err;

    always_comb begin
        s_zero   = (src_cls_i == CLS_ZERO);
        s_inf    = (src_cls_i == CLS_INF);
        s_qnan   = (src_cls_i == CLS_QNAN);
        s_nan    = s_qnan || (src_cls_i == CLS_SNAN);
        s_fin_nz = (src_cls_i == CLS_NORM) || (src_cls_i == CLS_DENORM);
        r_zero   = (reg_cls_i == CLS_ZERO);
        r_inf    = (reg_cls_i == CLS_INF);
        r_nan    = (reg_cls_i == CLS_QNAN) || (reg_cls_i == CLS_SNAN);
        s_negval = src_neg_i && (s_fin_nz || s_inf);
        s_big    = s_fin_nz && src_gt_one_i;
        any_nan  = s_nan || r_nan;
    end

    // raw domain decode per operation family
    always_comb begin
        raw_err = 1'b0;
        dyadic  = 1'b0;
        case (opcode_i)
            OP_ADD: begin
                dyadic  = 1'b1;
                raw_err = s_inf && r_inf && (src_neg_i != reg_neg_i);
            end
            OP_SUB: begin
                dyadic  = 1'b1;
                raw_err = s_inf && r_inf && (src_neg_i == reg_neg_i);
            end
            OP_MUL, OP_SMUL: begin
                dyadic  = 1'b1;
                raw_err = (s_zero && r_inf) || (s_inf && r_zero);
            end
            OP_DIV, OP_SDIV: begin
                dyadic  = 1'b1;
                raw_err = (s_zero && r_zero) || (s_inf && r_inf);
            end
            OP_ACOS, OP_ASIN, OP_ATANH:
                raw_err = s_inf || s_big;
            OP_SIN, OP_COS, OP_TAN, OP_SINCOS, OP_GEXP, OP_GMAN:
                raw_err = s_inf;
            OP_LN, OP_LOG2, OP_LOG10, OP_SQRT:
                raw_err = s_negval;
            OP_LNP1:
                raw_err = src_neg_i && (s_inf || s_big);
            OP_MOD, OP_REM: begin
                dyadic  = 1'b1;
                raw_err = r_inf || s_zero;
            end
            OP_SCALE: begin
                dyadic  = 1'b1;
                raw_err = s_inf;
            end
            OP_TOINT:
                raw_err = s_inf || s_qnan || (int_ovf_i && (s_zero || s_fin_nz));
            OP_TOPACK:
                raw_err = dec_exp_big_i || kfac_big_i;
            default: begin
                raw_err = 1'b0;
                dyadic  = 1'b0;
            end
        endcase
    end

    // a NaN operand overrides any two-operand domain error
    assign err_o = raw_err && !(dyadic && any_nan);

    // R4: an operation from the trig or get family never flags a finite source
    always_comb begin
        if ((opcode_i == OP_SIN || opcode_i == OP_GMAN) && s_fin_nz)
            assert_trig_finite_R4: assert (!err_o);
    end

endmodule

// File: rtl/fpe_policy_fsm.sv
module fpe_policy_fsm
    import fpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             err_i,
    input  logic             trap_en_i,
    input  logic [DST_W-1:0] dest_i,
    output logic             op_err_o,
    output logic             wr_en_o,
    output logic             force_nan_o,
    output logic             exc_req_o
);

    policy_state_e state_q, state_d;

    always_comb begin
        if (!valid_i)
            state_d = ST_IDLE;
        else if (!err_i)
            state_d = ST_PASS;
        else if (!trap_en_i)
            state_d = ST_NAN_QUIET;
        else if (dest_i == DST_FREG)
            state_d = ST_SUPPRESS;
        else
            state_d = ST_NAN_TRAP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        op_err_o    = 1'b0;
        wr_en_o     = 1'b0;
        force_nan_o = 1'b0;
        exc_req_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS:
                wr_en_o = 1'b1;
            ST_NAN_QUIET: begin
                op_err_o    = 1'b1;
                wr_en_o     = 1'b1;
                force_nan_o = 1'b1;
            end
            ST_SUPPRESS:
                op_err_o = 1'b1;
            ST_NAN_TRAP: begin
                op_err_o    = 1'b1;
                wr_en_o     = 1'b1;
                force_nan_o = 1'b1;
                exc_req_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!op_err_o && !wr_en_o && !force_nan_o && !exc_req_o));

    assert_no_trap_no_exc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !trap_en_i) |=> (!exc_req_o && wr_en_o));

    assert_freg_suppress_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && err_i && trap_en_i && dest_i == DST_FREG) |=> (!wr_en_o && !exc_req_o));

    assert_ext_trap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && err_i && trap_en_i && dest_i != DST_FREG) |=> (exc_req_o && force_nan_o));

endmodule

// File: rtl/fpe_sticky.sv
module fpe_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sticky_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sticky_o <= 1'b0;
        else if (set_i)
            sticky_o <= 1'b1;
        else if (clr_i)
            sticky_o <= 1'b0;
    end

endmodule

// File: rtl/fp_operr_detector.sv
module fp_operr_detector
    import fpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [CLS_W-1:0] src_cls_i,
    input  logic             src_neg_i,
    input  logic [CLS_W-1:0] reg_cls_i,
    input  logic             reg_neg_i,
    input  logic             src_gt_one_i,
    input  logic             int_ovf_i,
    input  logic             dec_exp_big_i,
    input  logic             kfac_big_i,
    input  logic [DST_W-1:0] dest_i,
    input  logic             trap_en_i,
    input  logic             clr_sticky_i,
    output logic             op_err_o,
    output logic             wr_en_o,
    output logic             force_nan_o,
    output logic             exc_req_o,
    output logic             sticky_o
);

    logic dom_err;

    fpe_domain_check u_domain (
        .opcode_i      (opcode_i),
        .src_cls_i     (src_cls_i),
        .src_neg_i     (src_neg_i),
        .reg_cls_i     (reg_cls_i),
        .reg_neg_i     (reg_neg_i),
        .src_gt_one_i  (src_gt_one_i),
        .int_ovf_i     (int_ovf_i),
        .dec_exp_big_i (dec_exp_big_i),
        .kfac_big_i    (kfac_big_i),
        .err_o         (dom_err)
    );

    fpe_policy_fsm u_policy (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .err_i       (dom_err),
        .trap_en_i   (trap_en_i),
        .dest_i      (dest_i),
        .op_err_o    (op_err_o),
        .wr_en_o     (wr_en_o),
        .force_nan_o (force_nan_o),
        .exc_req_o   (exc_req_o)
    );

    fpe_sticky u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (valid_i && dom_err),
        .clr_i    (clr_sticky_i),
        .sticky_o (sticky_o)
    );

    assert_sticky_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
        op_err_o |-> sticky_o);

    assert_sticky_clear_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky_i && !(valid_i && dom_err)) |=> !sticky_o);

    assert_clean_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dom_err) |=> (wr_en_o && !op_err_o && !force_nan_o));

endmodule

// File: tb/tb_fp_operr_detector.sv
module tb_fp_operr_detector;
    import fpe_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [4:0] opcode_i = '0;
    logic [2:0] src_cls_i = '0;
    logic       src_neg_i = 1'b0;
    logic [2:0] reg_cls_i = '0;
    logic       reg_neg_i = 1'b0;
    logic       src_gt_one_i = 1'b0;
    logic       int_ovf_i = 1'b0;
    logic       dec_exp_big_i = 1'b0;
    logic       kfac_big_i = 1'b0;
    logic [1:0] dest_i = '0;
    logic       trap_en_i = 1'b0;
    logic       clr_sticky_i = 1'b0;
    logic       op_err_o, wr_en_o, force_nan_o, exc_req_o, sticky_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit exp_sticky = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fp_operr_detector dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .src_cls_i(src_cls_i), .src_neg_i(src_neg_i), .reg_cls_i(reg_cls_i),
        .reg_neg_i(reg_neg_i), .src_gt_one_i(src_gt_one_i), .int_ovf_i(int_ovf_i),
        .dec_exp_big_i(dec_exp_big_i), .kfac_big_i(kfac_big_i), .dest_i(dest_i),
        .trap_en_i(trap_en_i), .clr_sticky_i(clr_sticky_i), .op_err_o(op_err_o),
        .wr_en_o(wr_en_o), .force_nan_o(force_nan_o), .exc_req_o(exc_req_o),
        .sticky_o(sticky_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL R10 watchdog: actual hung, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit is_nan(input logic [2:0] c);
        return (c == 3'd4) || (c == 3'd5);
    endfunction

    function automatic bit is_fin(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2);
    endfunction

    // reference model written from the requirement list
    function automatic bit ref_err(input logic [4:0] op, input logic [2:0] sc, input logic sn,
                                   input logic [2:0] rc, input logic rn, input logic g1,
                                   input logic ovf, input logic dx, input logic kf);
        bit e;
        bit two_op;
        e = 1'b0;
        two_op = (op <= 5'd5) || (op >= 5'd18 && op <= 5'd20);
        if (op == 5'd0) e = (sc == 3'd3) && (rc == 3'd3) && (sn ^ rn);
        else if (op == 5'd1) e = (sc == 3'd3) && (rc == 3'd3) && !(sn ^ rn);
        else if (op == 5'd2 || op == 5'd4)
            e = (sc == 3'd0 && rc == 3'd3) || (sc == 3'd3 && rc == 3'd0);
        else if (op == 5'd3 || op == 5'd5)
            e = (sc == 3'd0 && rc == 3'd0) || (sc == 3'd3 && rc == 3'd3);
        else if (op >= 5'd6 && op <= 5'd8) e = (sc == 3'd3) || (is_fin(sc) && g1);
        else if ((op >= 5'd9 && op <= 5'd12) || op == 5'd21 || op == 5'd22) e = (sc == 3'd3);
        else if (op >= 5'd13 && op <= 5'd16) e = sn && (is_fin(sc) || sc == 3'd3);
        else if (op == 5'd17) e = sn && ((sc == 3'd3) || (is_fin(sc) && g1));
        else if (op == 5'd18 || op == 5'd19) e = (rc == 3'd3) || (sc == 3'd0);
        else if (op == 5'd20) e = (sc == 3'd3);
        else if (op == 5'd23) e = (sc == 3'd3) || (sc == 3'd4) || (ovf && (sc <= 3'd2));
        else if (op == 5'd24) e = dx || kf;
        if (two_op && (is_nan(sc) || is_nan(rc))) e = 1'b0;
        return e;
    endfunction

    function automatic string op_tag(input logic [4:0] op);
        if (op <= 5'd1) return "R1";
        if (op <= 5'd5) return "R2";
        if (op <= 5'd8) return "R3";
        if (op <= 5'd12 || op == 5'd21 || op == 5'd22) return "R4";
        if (op <= 5'd16) return "R5";
        if (op == 5'd17) return "R6";
        if (op <= 5'd20) return "R7";
        if (op == 5'd23) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // drive one operation at a negedge, check at the following negedge
    task automatic run_op(input logic [4:0] op, input logic [2:0] sc, input logic sn,
                          input logic [2:0] rc, input logic rn, input logic g1,
                          input logic ovf, input logic dx, input logic kf,
                          input logic [1:0] dst, input logic trap, input logic clr);
        bit e, ext;
        string ptag;
        valid_i = 1'b1; opcode_i = op; src_cls_i = sc; src_neg_i = sn;
        reg_cls_i = rc; reg_neg_i = rn; src_gt_one_i = g1; int_ovf_i = ovf;
        dec_exp_big_i = dx; kfac_big_i = kf; dest_i = dst; trap_en_i = trap;
        clr_sticky_i = clr;
        e = ref_err(op, sc, sn, rc, rn, g1, ovf, dx, kf);
        ext = (dst != 2'd0);
        if (e) exp_sticky = 1'b1;
        else if (clr) exp_sticky = 1'b0;
        ptag = !e ? "R10" : (!trap ? "R11" : (ext ? "R13" : "R12"));
        @(posedge clk);
        @(negedge clk);
        chk(op_tag(op), "op_err", op_err_o, e);
        chk(ptag, "wr_en", wr_en_o, !e || !trap || ext);
        chk(ptag, "force_nan", force_nan_o, e && (!trap || ext));
        chk(ptag, "exc_req", exc_req_o, e && trap && ext);
        chk("R14", "sticky", sticky_o, exp_sticky);
    endtask

    task automatic idle_cycle(input logic clr);
        valid_i = 1'b0; clr_sticky_i = clr;
        if (clr) exp_sticky = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "idle op_err", op_err_o, 1'b0);
        chk("R10", "idle wr_en", wr_en_o, 1'b0);
        chk("R10", "idle force_nan", force_nan_o, 1'b0);
        chk("R10", "idle exc_req", exc_req_o, 1'b0);
        chk("R14", "idle sticky", sticky_o, exp_sticky);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R10", "reset op_err", op_err_o, 1'b0);
        chk("R10", "reset wr_en", wr_en_o, 1'b0);
        chk("R10", "reset sticky", sticky_o, 1'b0);
        rst_n = 1'b1;
        idle_cycle(1'b0);

        // R1 infinities in add and subtract
        run_op(5'd0, 3'd3, 0, 3'd3, 1, 0, 0, 0, 0, 2'd0, 0, 0);
        run_op(5'd0, 3'd3, 0, 3'd3, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        run_op(5'd1, 3'd3, 1, 3'd3, 1, 0, 0, 0, 0, 2'd0, 0, 0);
        // R2 zero times infinity, infinity over infinity, NaN cancels
        run_op(5'd4, 3'd0, 0, 3'd3, 0, 0, 0, 0, 0, 2'd1, 0, 0);
        run_op(5'd5, 3'd3, 0, 3'd3, 1, 0, 0, 0, 0, 2'd0, 0, 0);
        run_op(5'd3, 3'd4, 0, 3'd3, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        // R3 inverse trig domain
        run_op(5'd6, 3'd1, 1, 3'd1, 0, 1, 0, 0, 0, 2'd0, 0, 0);
        run_op(5'd8, 3'd1, 0, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        // R4 trig on infinity
        run_op(5'd12, 3'd3, 0, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        // R5 negative zero versus negative normal
        run_op(5'd16, 3'd0, 1, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        run_op(5'd14, 3'd2, 1, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        // R6 exact minus one versus below minus one
        run_op(5'd17, 3'd1, 1, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        run_op(5'd17, 3'd3, 1, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        // R7 modulo with infinite register, NaN exemption, scale
        run_op(5'd18, 3'd1, 0, 3'd3, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        run_op(5'd19, 3'd4, 0, 3'd3, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        run_op(5'd20, 3'd3, 0, 3'd5, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        // R8 signaling versus quiet NaN into integer conversion
        run_op(5'd23, 3'd5, 0, 3'd1, 0, 0, 1, 0, 0, 2'd2, 0, 1);
        run_op(5'd23, 3'd4, 0, 3'd1, 0, 0, 0, 0, 0, 2'd2, 0, 0);
        // R9 packed decimal limits and an opcode that never flags
        run_op(5'd24, 3'd1, 0, 3'd1, 0, 0, 0, 0, 1, 2'd1, 0, 0);
        run_op(5'd25, 3'd3, 1, 3'd3, 0, 1, 1, 1, 1, 2'd0, 0, 1);
        // R12 and R13 trap policies
        run_op(5'd3, 3'd0, 0, 3'd0, 0, 0, 0, 0, 0, 2'd0, 1, 0);
        run_op(5'd24, 3'd1, 0, 3'd1, 0, 0, 0, 1, 0, 2'd1, 1, 0);
        run_op(5'd23, 3'd3, 0, 3'd1, 0, 0, 0, 0, 0, 2'd2, 1, 0);
        // R14 clear pulse together with a flagged operation keeps the bit
        run_op(5'd9, 3'd3, 0, 3'd1, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        idle_cycle(1'b1);
        idle_cycle(1'b0);

        for (int i = 0; i < 600; i++) begin
            if (($urandom % 8) == 0)
                idle_cycle(1'(($urandom % 4) == 0));
            else
                run_op(5'($urandom % 27), 3'($urandom % 6), 1'($urandom),
                       3'($urandom % 6), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                       1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 2'($urandom % 3),
                       1'($urandom), 1'($urandom % 6 == 0));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule